// File: doc/BRIEF.md
# SPI Password Unlock Engine

This block is the slave-side front end of a serial flash that handles one command: a password unlock. The host pulls chip select low and shifts in an 8-bit instruction, then a 64-bit password. Bits are taken from SI on rising SCK edges. When chip select returns high, the engine checks that exactly one instruction byte and 64 password bits were received. If they were, it starts a self-timed compare of the password against a hidden password word that is held outside the block.

A match sets a volatile protection lock bit. A mismatch raises an error flag and keeps the busy flag high. The busy flag then stays up until the host issues a status clear, a software reset, or a hardware reset. Both status clear and software reset leave the lock bit alone. Only the active-low hardware reset clears it.

The SPI pins are sampled in the core clock domain through synchronisers. The core clock must therefore run well above the SCK rate.

Top module: `pwu_unlock`

## Requirements
- R1: After `rst_ni` is released, `wip_o`, `perr_o` and `lock_o` are all 0.
- R2: A frame of instruction 0xE9 (sent MSB first) and 64 password bits, closed by chip select rising, starts an operation. During the operation `wip_o` is 1 for `OP_CYCLES` core cycles (default 8). If the password matches, the operation then sets `lock_o` to 1 and returns `wip_o` to 0, with `perr_o` staying 0.
- R3: The password is assembled with byte 0 (bits 7:0) first, and each byte is sent MSB first. A password that does not match `hidden_pw_i` sets `perr_o` to 1 and leaves `wip_o` at 1.
- R4: If chip select rises after any number of password bits other than 64 (for example 63 or 65), the frame has no effect on any output.
- R5: A frame whose instruction byte is not 0xE9 has no effect on any output.
- R6: A one-cycle `clr_sts_i` pulse returns `wip_o` and `perr_o` to 0. A later valid frame is then accepted again.
- R7: A one-cycle `soft_rst_i` pulse returns `wip_o` and `perr_o` to 0 and keeps `lock_o` at its current value.
- R8: Asserting `rst_ni` low clears `lock_o`.
- R9: While `wip_o` is 1, new unlock frames are ignored. `perr_o` stays 1 and `lock_o` stays unchanged until a clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| hidden_pw_i | input | 64 | Stored password word, byte 0 in bits 7:0 |
| clr_sts_i | input | 1 | Clear-status command pulse |
| soft_rst_i | input | 1 | Software reset command pulse |
| wip_o | output | 1 | Operation in progress / stuck on error |
| perr_o | output | 1 | Password error flag |
| lock_o | output | 1 | Protection lock bit |

## Verification
The assertions assume three things about the inputs. SCK is slow enough that each level lasts several core cycles. SI is stable around each rising SCK edge. `hidden_pw_i` does not change while a compare is under way. The stimulus holds every SCK level for four core cycles, changes SI only while SCK is low, and loads the password word before the first frame. It then keeps that word unchanged for the rest of the run. Clear and software-reset pulses are sent only while chip select is high and no frame is being shifted in.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int unsigned OP_BITS   = 8;
  localparam logic [OP_BITS-1:0] UNLOCK_OP = 8'hE9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FAIL = 2'd2
  } pwu_state_e;
endpackage

// File: rtl/pwu_sync.sv
module pwu_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwu_shifter.sv
module pwu_shifter
  import pwu_pkg::*;
#(
  parameter int unsigned PW_BYTES = 8,
  localparam int unsigned PW_BITS    = PW_BYTES * 8,
  localparam int unsigned FRAME_BITS = OP_BITS + PW_BITS,
  localparam int unsigned CW         = $clog2(FRAME_BITS + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_s_i,
  input  logic               sck_s_i,
  input  logic               si_s_i,
  output logic               frame_ok_o,
  output logic [PW_BITS-1:0] pw_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_OP   = CW'(OP_BITS);

  logic               sck_q, cs_q;
  logic [CW-1:0]      cnt_q;
  logic [OP_BITS-1:0] op_q;
  logic [PW_BITS-1:0] sh_q;
  logic               sck_rise, cs_rise;

  assign sck_rise = sck_s_i & ~sck_q;
  assign cs_rise  = cs_s_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      op_q  <= '0;
      sh_q  <= '0;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_s_i;
      if (cs_s_i) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        if (cnt_q < CNT_OP)        op_q <= {op_q[OP_BITS-2:0], si_s_i};
        else if (cnt_q < CNT_FULL) sh_q <= {sh_q[PW_BITS-2:0], si_s_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // first byte on the wire lands in the top byte of sh_q; it is password byte 0
  for (genvar b = 0; b < PW_BYTES; b++) begin : g_swap
    assign pw_o[b*8 +: 8] = sh_q[(PW_BYTES-1-b)*8 +: 8];
  end

  assign frame_ok_o = cs_rise && (cnt_q == CNT_FULL) && (op_q == UNLOCK_OP);
endmodule

// File: rtl/pwu_ctrl.sv
module pwu_ctrl
  import pwu_pkg::*;
#(
  parameter int unsigned PW_BITS   = 64,
  parameter int unsigned OP_CYCLES = 8,
  localparam int unsigned TW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PW_BITS-1:0] pw_i,
  input  logic [PW_BITS-1:0] hidden_pw_i,
  input  logic               clr_sts_i,
  input  logic               soft_rst_i,
  output logic               wip_o,
  output logic               perr_o,
  output logic               lock_o
);
  pwu_state_e    st_q;
  logic [TW-1:0] tmr_q;
  logic          match_q;
  logic          perr_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      match_q <= 1'b0;
      perr_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (clr_sts_i || soft_rst_i) begin
      st_q   <= ST_IDLE;
      perr_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_BUSY;
          tmr_q   <= TW'(OP_CYCLES - 1);
          match_q <= (pw_i == hidden_pw_i);
        end
        ST_BUSY: begin
          if (tmr_q == '0) begin
            if (match_q) begin
              st_q   <= ST_IDLE;
              lock_q <= 1'b1;
            end else begin
              st_q   <= ST_FAIL;
              perr_q <= 1'b1;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_FAIL: ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wip_o  = (st_q != ST_IDLE);
  assign perr_o = perr_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/pwu_unlock.sv
module pwu_unlock
  import pwu_pkg::*;
#(
  parameter int unsigned PW_BYTES    = 8,
  parameter int unsigned OP_CYCLES   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW_BITS = PW_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               si_i,
  input  logic [PW_BITS-1:0] hidden_pw_i,
  input  logic               clr_sts_i,
  input  logic               soft_rst_i,
  output logic               wip_o,
  output logic               perr_o,
  output logic               lock_o
);
  logic cs_s, sck_s, si_s, frame_ok;
  logic [PW_BITS-1:0] pw;

  pwu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));
  pwu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));
  pwu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(si_i), .q_o(si_s));

  pwu_shifter #(.PW_BYTES(PW_BYTES)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_s_i(cs_s), .sck_s_i(sck_s), .si_s_i(si_s),
    .frame_ok_o(frame_ok), .pw_o(pw));

  pwu_ctrl #(.PW_BITS(PW_BITS), .OP_CYCLES(OP_CYCLES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(frame_ok), .pw_i(pw), .hidden_pw_i(hidden_pw_i),
    .clr_sts_i(clr_sts_i), .soft_rst_i(soft_rst_i),
    .wip_o(wip_o), .perr_o(perr_o), .lock_o(lock_o));
endmodule

// File: rtl/pwu_unlock_chk.sv
module pwu_unlock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic clr_sts_i,
  input logic soft_rst_i,
  input logic wip_o,
  input logic perr_o,
  input logic lock_o
);
  assert_perr_holds_wip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> wip_o);

  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  assert_clear_idles_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sts_i || soft_rst_i) |=> (!wip_o && !perr_o));

  assert_start_after_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cs_ni));

  assert_lock_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($fell(wip_o) && !perr_o));

  assert_err_stuck_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o && !clr_sts_i && !soft_rst_i) |=> perr_o);
endmodule

bind pwu_unlock pwu_unlock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
  .clr_sts_i(clr_sts_i), .soft_rst_i(soft_rst_i),
  .wip_o(wip_o), .perr_o(perr_o), .lock_o(lock_o));

// File: tb/sim_pwu_unlock.sv
`timescale 1ns/1ps
module sim_pwu_unlock;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, si = 1'b0;
  logic clr_sts = 1'b0, soft_rst = 1'b0;
  logic [63:0] hidden = 64'h0123_4567_89AB_CDEF;
  logic wip, perr, lock;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwu_unlock u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .si_i(si),
    .hidden_pw_i(hidden), .clr_sts_i(clr_sts), .soft_rst_i(soft_rst),
    .wip_o(wip), .perr_o(perr), .lock_o(lock));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {wip,perr,lock} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    si = b;
    wait_clk(4);
    sck = 1'b1;
    wait_clk(4);
    sck = 1'b0;
  endtask

  // op MSB first, then password byte 0 first, each byte MSB first
  task automatic send_frame(input logic [7:0] op, input logic [63:0] pw, input int nbits);
    cs_ni = 1'b0;
    wait_clk(4);
    for (int i = 7; i >= 0; i--) shift_bit(op[i]);
    for (int k = 0; k < nbits; k++) shift_bit(pw[(k/8)*8 + 7 - (k%8)]);
    wait_clk(4);
    cs_ni = 1'b1;
  endtask

  task automatic pulse(input bit which_soft);
    if (which_soft) soft_rst = 1'b1; else clr_sts = 1'b1;
    wait_clk(1);
    soft_rst = 1'b0;
    clr_sts = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset();
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(3);
    chk("R1 reset", {wip, perr, lock}, 3'b000);
  endtask

  task automatic t_bad_length();
    send_frame(8'hE9, hidden, 63);
    wait_clk(20);
    chk("R4 63 bits", {wip, perr, lock}, 3'b000);
    send_frame(8'hE9, hidden, 65);
    wait_clk(20);
    chk("R4 65 bits", {wip, perr, lock}, 3'b000);
  endtask

  task automatic t_bad_op();
    send_frame(8'hE8, hidden, 64);
    wait_clk(20);
    chk("R5 opcode E8", {wip, perr, lock}, 3'b000);
    send_frame(8'h69, hidden, 64);
    wait_clk(20);
    chk("R5 opcode 69", {wip, perr, lock}, 3'b000);
  endtask

  task automatic t_mismatch_order();
    // bytes sent in reversed order must not match
    send_frame(8'hE9, {<<8{hidden}}, 64);
    wait_clk(4);
    chk("R3 busy", {wip, perr, lock}, 3'b100);
    wait_clk(16);
    chk("R3 error", {wip, perr, lock}, 3'b110);
    wait_clk(40);
    chk("R3 stuck", {wip, perr, lock}, 3'b110);
  endtask

  task automatic t_ignore_busy();
    send_frame(8'hE9, hidden, 64);
    wait_clk(20);
    chk("R9 ignored while wip", {wip, perr, lock}, 3'b110);
  endtask

  task automatic t_clear_retry();
    pulse(1'b0);
    chk("R6 cleared", {wip, perr, lock}, 3'b000);
    send_frame(8'hE9, hidden, 64);
    wait_clk(4);
    chk("R2 busy during op", {wip, perr, lock}, 3'b100);
    wait_clk(16);
    chk("R2 R6 match locks", {wip, perr, lock}, 3'b001);
  endtask

  task automatic t_soft_reset();
    send_frame(8'hE9, hidden ^ 64'h1, 64);
    wait_clk(20);
    chk("R3 bit0 mismatch", {wip, perr, lock}, 3'b111);
    pulse(1'b1);
    chk("R7 soft reset keeps lock", {wip, perr, lock}, 3'b001);
  endtask

  task automatic t_hard_reset();
    rst_ni = 1'b0;
    wait_clk(2);
    rst_ni = 1'b1;
    wait_clk(2);
    chk("R8 hard reset clears lock", {wip, perr, lock}, 3'b000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_bad_length();
    t_bad_op();
    t_mismatch_order();
    t_ignore_busy();
    t_clear_retry();
    t_soft_reset();
    t_hard_reset();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule